// File: doc/BRIEF.md
# Fixed-OR Sum-of-Products Logic Array

This block is a configurable two-level logic device. A programmable AND plane forms product terms from sixteen array signals, each available in true and complemented form. A fixed OR plane then combines them. Each of the eight outputs owns eight product terms. One term decides whether the pin drives. The other seven are ORed together, and the result is inverted to give the pin value. Terms are never shared between outputs.

Ten array signals come straight from dedicated input pins. The other six come from output pins 1 to 6. While such a pin drives, the array sees the value the pin is driving. While it does not drive, the array sees the level applied to the pin from outside. Tri-state pins are modelled as a data output, an enable output and a separate pin-input port.

The connection pattern is a 2048-bit register loaded serially, most significant bit first, while a load strobe is high. All outputs are held undriven during loading. The configurations used must not close a combinational loop through driving feedback pins.

Top module: `sop_array`

## Requirements
- R1: After reset the whole connection register is 1, so every term is false: every `out_oe` bit is 0 and every `out_data` bit is 1.
- R2: Each clock with `cfg_load` high shifts `cfg_bit` into bit 0 and moves every bit up by one place. After 2048 loads, the first bit sent sits at index 2047. Bit index = (output*8 + term)*32 + literal.
- R3: While `cfg_load` is low the connection register holds, so `cfg_bit` has no effect on any output.
- R4: Literal 2s is the true form of array signal s and literal 2s+1 is its complement. Signals 0..9 are `in_pins[0..9]`. Signal 10+k is the feedback of output k+1 (k = 0..5). A connection bit of 1 puts the literal into the term.
- R5: A term with no connection bits set is true. A term that contains a signal and its complement is false.
- R6: `out_data[o]` is the complement of the OR of terms 1..7 of output o, and no term of another output affects it.
- R7: Term 0 of output o is its enable: while `cfg_load` is low, `out_oe[o]` equals that term.
- R8: While `cfg_load` is high every `out_oe` bit is 0.
- R9: Array signal 10+k is `out_data[k+1]` when `out_oe[k+1]` is 1, and `fb_pin_in[k]` when it is 0. Outputs 0 and 7 never feed back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the connection register |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_load | input | 1 | Shift strobe for the connection register; disables all outputs |
| cfg_bit | input | 1 | Serial configuration data, most significant bit first |
| in_pins | input | 10 | Dedicated array inputs (signals 0..9) |
| fb_pin_in | input | 6 | External level on output pins 1..6 when they are not driving |
| out_data | output | 8 | Pin values, each the inverted OR of its seven terms |
| out_oe | output | 8 | Per-pin drive enable from each output's enable term |

## Verification
The only state is the connection register. A wrong or misaligned bit shows up as a wrong product term on one particular output, for the input patterns that the affected literal decides. After the last shift clock, the fault is visible at the ports at once and combinationally. Sweeping every input pattern with a configuration that uses both literal polarities, both end bits of the shift order and a chained feedback path exposes it within one sweep. A disturbed register while loading is idle appears as a changed output without any new input.

// File: rtl/sop_pkg.sv
package sop_pkg;
  localparam int unsigned SOP_N_IN    = 10;
  localparam int unsigned SOP_N_OUT   = 8;
  localparam int unsigned SOP_N_FB    = 6;
  localparam int unsigned SOP_FB_BASE = 1;
  localparam int unsigned SOP_N_SUM   = 7;
endpackage

// File: rtl/sop_cfg_chain.sv
module sop_cfg_chain #(
  parameter int W = 2048
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (shift_en) q_nxt = {q[W-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '1;
    else        q <= q_nxt;
  end

  assert_shift_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> q[0] == $past(din));
  assert_shift_walk_R2: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> q[W-1:1] == $past(q[W-2:0]));
  assert_hold_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(q));
endmodule

// File: rtl/sop_term.sv
module sop_term #(
  parameter int N_SIG = 16,
  localparam int L = 2 * N_SIG
) (
  input  logic [N_SIG-1:0] sig,
  input  logic [L-1:0]     mask,
  output logic             hit
);
  logic [L-1:0] lit;

  for (genvar s = 0; s < N_SIG; s++) begin : g_lit
    assign lit[2*s]   = sig[s];
    assign lit[2*s+1] = ~sig[s];
  end

  assign hit = &(lit | ~mask);
endmodule

// File: rtl/sop_cell.sv
module sop_cell #(
  parameter int N_SIG = 16,
  parameter int N_SUM = 7,
  localparam int N_TERM = N_SUM + 1,
  localparam int L = 2 * N_SIG
) (
  input  logic [N_SIG-1:0]    sig,
  input  logic [N_TERM*L-1:0] cfg,
  input  logic                hold,
  output logic                data,
  output logic                oe
);
  logic [N_TERM-1:0] hits;

  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    sop_term #(.N_SIG(N_SIG)) u_term (
      .sig  (sig),
      .mask (cfg[t*L +: L]),
      .hit  (hits[t])
    );
  end

  assign data = ~(|hits[N_TERM-1:1]);
  assign oe   = hits[0] & ~hold;
endmodule

// File: rtl/sop_array.sv
module sop_array
  import sop_pkg::*;
#(
  parameter int N_IN    = SOP_N_IN,
  parameter int N_OUT   = SOP_N_OUT,
  parameter int N_FB    = SOP_N_FB,
  parameter int FB_BASE = SOP_FB_BASE,
  parameter int N_SUM   = SOP_N_SUM
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_load,
  input  logic             cfg_bit,
  input  logic [N_IN-1:0]  in_pins,
  input  logic [N_FB-1:0]  fb_pin_in,
  output logic [N_OUT-1:0] out_data,
  output logic [N_OUT-1:0] out_oe
);
  localparam int N_SIG     = N_IN + N_FB;
  localparam int L         = 2 * N_SIG;
  localparam int N_TERM    = N_SUM + 1;
  localparam int CELL_BITS = N_TERM * L;
  localparam int CFG_BITS  = N_OUT * CELL_BITS;

  logic [1:0]          rst_pipe;
  logic                rst_s;
  logic [CFG_BITS-1:0] cfg_q;
  logic [N_SIG-1:0]    sig;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  sop_cfg_chain #(.W(CFG_BITS)) u_chain (
    .clk      (clk),
    .rst_n    (rst_s),
    .shift_en (cfg_load),
    .din      (cfg_bit),
    .q        (cfg_q)
  );

  assign sig[N_IN-1:0] = in_pins;
  for (genvar k = 0; k < N_FB; k++) begin : g_fb
    assign sig[N_IN+k] = out_oe[FB_BASE+k] ? out_data[FB_BASE+k] : fb_pin_in[k];
  end

  for (genvar o = 0; o < N_OUT; o++) begin : g_cell
    sop_cell #(.N_SIG(N_SIG), .N_SUM(N_SUM)) u_cell (
      .sig  (sig),
      .cfg  (cfg_q[o*CELL_BITS +: CELL_BITS]),
      .hold (cfg_load),
      .data (out_data[o]),
      .oe   (out_oe[o])
    );
  end

  assert_load_dark_R8: assert property (@(posedge clk) disable iff (!rst_s)
    cfg_load |-> out_oe == '0);
  assert_reset_blank_R1: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(rst_s) |-> (out_oe == '0 && out_data == '1));
  assert_idle_steady_R3: assert property (@(posedge clk) disable iff (!rst_s)
    (!cfg_load && $past(!cfg_load) && $stable(in_pins) && $stable(fb_pin_in))
      |-> ($stable(out_data) && $stable(out_oe)));
endmodule

// File: tb/sim_sop_array.sv
`timescale 1ns/1ps
module sim_sop_array;
  localparam realtime CLK = 8.0;

  logic clk = 1'b0, rst_n = 1'b0, cfg_load = 1'b0, cfg_bit = 1'b0;
  logic [9:0] in_pins = '0;
  logic [5:0] fb_pin_in = '0;
  logic [7:0] out_data, out_oe;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  bit [2047:0] cfg_m;

  always #(CLK/2) clk = ~clk;

  sop_array u0 (.clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_bit(cfg_bit),
    .in_pins(in_pins), .fb_pin_in(fb_pin_in), .out_data(out_data), .out_oe(out_oe));

  function automatic bit term_val(int o, int t, logic [15:0] s);
    for (int l = 0; l < 32; l++) begin
      if (cfg_m[(o*8+t)*32+l]) begin
        if (((l % 2) ? ~s[l/2] : s[l/2]) == 1'b0) return 1'b0;
      end
    end
    return 1'b1;
  endfunction

  task automatic model(output logic [7:0] d, output logic [7:0] e);
    logic [15:0] s;
    s = {fb_pin_in, in_pins};
    d = '1; e = '0;
    for (int p = 0; p < 9; p++) begin
      for (int o = 0; o < 8; o++) begin
        bit any = 0;
        for (int t = 1; t < 8; t++) any |= term_val(o, t, s);
        d[o] = ~any;
        e[o] = term_val(o, 0, s);
      end
      for (int k = 0; k < 6; k++) s[10+k] = e[1+k] ? d[1+k] : fb_pin_in[k];
    end
  endtask

  task automatic check_outs(string req);
    logic [7:0] d, e;
    model(d, e);
    n_chk++;
    if (out_data !== d || out_oe !== e) begin
      n_bad++;
      $display("FAIL %s in=%h fb=%h data=%h/%h oe=%h/%h (actual/expected)",
               req, in_pins, fb_pin_in, out_data, d, out_oe, e);
    end
  endtask

  task automatic set_lit(int o, int t, int l, bit v);
    cfg_m[(o*8+t)*32+l] = v;
  endtask

  task automatic clear_term(int o, int t);
    for (int l = 0; l < 32; l++) set_lit(o, t, l, 1'b0);
  endtask

  initial begin
    #(CLK * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset leaves every term false
    cfg_m = '1;
    in_pins = 10'h2a5; fb_pin_in = 6'h15; #2;
    n_chk++;
    if (out_oe !== 8'h00 || out_data !== 8'hff) begin
      n_bad++;
      $display("FAIL R1 data=%h/ff oe=%h/00", out_data, out_oe);
    end

    // Configuration: out0 = in0 xor in1 (R5 always-on enable, R4 literals)
    clear_term(0, 0);
    clear_term(0, 1); set_lit(0, 1, 0, 1); set_lit(0, 1, 2, 1);
    clear_term(0, 2); set_lit(0, 2, 1, 1); set_lit(0, 2, 3, 1);
    // out1 disabled: pin acts as input (R9)
    // out2: enable = in2, term1 = sig10 & in3
    clear_term(2, 0); set_lit(2, 0, 4, 1);
    clear_term(2, 1); set_lit(2, 1, 20, 1); set_lit(2, 1, 6, 1);
    // out3: always on, term1 = sig11 (feedback of out2)
    clear_term(3, 0);
    clear_term(3, 1); set_lit(3, 1, 22, 1);
    // out7: enable = ~in9, terms in4 | ~in5&in6 | ~sig15; bit 2047 used (R2)
    clear_term(7, 0); set_lit(7, 0, 19, 1);
    clear_term(7, 1); set_lit(7, 1, 8, 1);
    clear_term(7, 2); set_lit(7, 2, 11, 1); set_lit(7, 2, 12, 1);
    clear_term(7, 7); set_lit(7, 7, 31, 1);

    for (int i = 2047; i >= 0; i--) begin
      @(negedge clk);
      cfg_load = 1'b1; cfg_bit = cfg_m[i];
      if (i == 1000 || i == 5) begin
        #1; n_chk++;
        if (out_oe !== 8'h00) begin
          n_bad++;
          $display("FAIL R8 oe=%h expected 00 during load", out_oe);
        end
      end
    end
    @(negedge clk);
    cfg_load = 1'b0;
    #1; check_outs("R2 after load");

    // R3: serial data toggles with load low
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); cfg_bit = i[0];
    end
    #1; check_outs("R3 idle toggling");

    // R4 R5 R6 R7 R9: exhaustive sweep
    for (int p = 0; p < 4096; p++) begin
      @(negedge clk);
      in_pins = p[9:0];
      fb_pin_in = {p[11], p[1] ^ p[3], p[10], p[2], p[11] ^ p[0], p[10]};
      #2; check_outs("R6/R7/R9 sweep");
    end

    // R8: single-cycle load strobe blanks outputs
    @(negedge clk);
    in_pins = 10'h004; cfg_load = 1'b1; cfg_bit = 1'b0; #1;
    n_chk++;
    if (out_oe !== 8'h00) begin
      n_bad++;
      $display("FAIL R8 oe=%h expected 00", out_oe);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule